// File: doc/BRIEF.md
# Exception Stack Frame Engine

This block is the sequencer a processor core hands control to when an exception is taken and when a return-from-exception is executed. On entry it receives the exception number, whether the cause is a hardware interrupt, the current status register, PC, active stack pointer, interrupt stack pointer, pending interrupt level, a fault address, a frame format and the vector base. It works out the new status register, writes the stack frame one memory access at a time at descending addresses, and then reads the handler address from the vector table.

On return it reads the frame back from the stack and steps over each format's extra fields by that format's own size. A format 1 frame is a throwaway frame: unwinding restarts just above it. All memory traffic goes through a single request/acknowledge port that carries one 16-bit or 32-bit big-endian access at a time. The new status register, PC and stack pointers appear on the outputs, together with a one-cycle `done` pulse, only when the whole sequence has finished.

Top module: `exc_frame_engine`

## Requirements
- R1: A frame occupies increasing addresses from its base: the stacked status word (16 bits) at base, the return address (32 bits) at base+2, the format/vector word (16 bits) at base+6, and the extra fields from base+8 upward. `sp_out` on entry is the frame base.
- R2: The format/vector word has the format in bits 15:12 and the exception number shifted left by two in bits 11:0.
- R3: Extra fields depend on the format. Formats 2 and 3 hold the fault address at base+8. Format 4 holds the fault address at base+8 and the entry PC at base+12. Every other format has no extra fields.
- R4: The stacked return address is `pc_in`+2 for exception numbers 32 to 47 (software traps) and `pc_in` otherwise.
- R5: The new status register is `sr_in` with bit 13 (supervisor) set and bits 15:14 (trace) cleared. For a hardware cause, bits 10:8 are replaced by `ipl`. The stacked status word is the unmodified `sr_in`.
- R6: With `UNALIGNED_OK`=0, bit 0 of `sp_in` and of `isp_in` is cleared before any push, so no write goes to an odd address.
- R7: A hardware cause with exception number 24 to 31 and `sr_in` bit 12 (master) set produces two frames. A format 0 frame goes on the `sp_in` stack, and `msp_out` gives its base. A format 1 frame then goes on the `isp_in` stack, holding the new status with bit 12 still set. `sr_out` then has bit 12 cleared, and `sp_out` is the base of the second frame. Without this case, `msp_out` equals `sp_out`.
- R8: After the pushes, a 32-bit read at `vbr`+4×exception number supplies `pc_out`.
- R9: Return reads the status word at `sp_in`, the PC at `sp_in`+2 and the format word at `sp_in`+6. It then sets `sr_out` and `pc_out` to the values read, and sets `sp_out` = `msp_out` = `sp_in`+8+skip. The skip is 4 for formats 2 and 3, 8 for format 4, 52 for format 7 and 0 for every other format. Return performs no writes.
- R10: On return, a format 1 frame's status and PC are discarded, and unwinding restarts at its address+8.
- R11: One access is in flight at a time. Request, address, size and write flag stay stable until `mem_ack`. Word data travels in bits 15:0. `done` is a single-cycle pulse. `entry_go` and `return_go` are ignored while `busy` is high. The result outputs change only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_go | input | 1 | Start an exception entry (has priority over return) |
| return_go | input | 1 | Start a return-from-exception |
| exc_num | input | VEC_W | Exception number |
| is_hw | input | 1 | Cause is a hardware interrupt |
| sr_in | input | 16 | Current status register |
| pc_in | input | AW | Current PC |
| sp_in | input | AW | Active stack pointer |
| isp_in | input | AW | Interrupt stack pointer, used for the second frame |
| ipl | input | 3 | Pending interrupt level |
| fault_addr | input | AW | Fault address for the format 2, 3 and 4 extras |
| frame_fmt | input | 4 | Frame format for entry |
| vbr | input | AW | Vector table base |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| sr_out | output | 16 | Committed status register |
| pc_out | output | AW | Committed PC |
| sp_out | output | AW | Committed stack pointer |
| msp_out | output | AW | Committed pointer on the stack where entry began |
| mem_req | output | 1 | Access request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_long | output | 1 | 32-bit (1) or 16-bit (0) access |
| mem_addr | output | AW | Byte address of the most significant byte |
| mem_wdata | output | 32 | Write data; a word uses bits 15:0 |
| mem_rdata | input | 32 | Read data; a word uses bits 15:0 |
| mem_ack | input | 1 | Access complete this cycle |

## Verification
Every access costs one request cycle plus however long the acknowledge takes. The bench memory answers on the cycle after a request, so each access takes two clocks. The results and `done` are registered on the edge that accepts the final acknowledge: the vector read on entry, or the last format word read on return. They are therefore valid from that edge until the next completion. The bench starts each sequence at a falling edge and polls `done` at every falling edge. It samples the outputs in the cycle where `done` is high, and reads the frame contents back from its memory model only after that point. Between sequences it also checks that the outputs held still while `busy` was high.

// File: rtl/esf_pkg.sv
package esf_pkg;

  localparam int LONG_W    = 32;
  localparam int SR_W      = 16;
  localparam int SR_T_HI   = 15;
  localparam int SR_T_LO   = 14;
  localparam int SR_S_BIT  = 13;
  localparam int SR_M_BIT  = 12;
  localparam int SR_I_LO   = 8;
  localparam int IPL_W     = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_VEC,
    ST_POP_SR,
    ST_POP_PC,
    ST_POP_FVW
  } esf_state_e;

  // One pushed field of a frame, listed from the highest address down
  typedef enum logic [2:0] {
    K_EXT_PC,
    K_EXT_ADDR,
    K_FVW,
    K_RET,
    K_SR
  } esf_kind_e;

  function automatic esf_kind_e first_kind(input logic [3:0] fmt);
    case (fmt)
      4'd4:       return K_EXT_PC;
      4'd2, 4'd3: return K_EXT_ADDR;
      default:    return K_FVW;
    endcase
  endfunction

  function automatic esf_kind_e next_kind(input esf_kind_e k);
    case (k)
      K_EXT_PC:   return K_EXT_ADDR;
      K_EXT_ADDR: return K_FVW;
      K_FVW:      return K_RET;
      default:    return K_SR;
    endcase
  endfunction

  function automatic logic kind_is_long(input esf_kind_e k);
    return (k == K_EXT_PC) || (k == K_EXT_ADDR) || (k == K_RET);
  endfunction

  // Bytes of extra fields stepped over on return
  function automatic logic [5:0] unwind_skip(input logic [3:0] fmt);
    case (fmt)
      4'd2, 4'd3: return 6'd4;
      4'd4:       return 6'd8;
      4'd7:       return 6'd52;
      default:    return 6'd0;
    endcase
  endfunction

endpackage

// File: rtl/esf_entry_calc.sv
module esf_entry_calc
  import esf_pkg::*;
#(
  parameter int AW           = 32,
  parameter int VEC_W        = 8,
  parameter bit UNALIGNED_OK = 1'b0
) (
  input  logic [VEC_W-1:0] exc_num,
  input  logic             is_hw,
  input  logic [SR_W-1:0]  sr_in,
  input  logic [AW-1:0]    pc_in,
  input  logic [AW-1:0]    sp_in,
  input  logic [AW-1:0]    isp_in,
  input  logic [IPL_W-1:0] ipl,
  output logic [SR_W-1:0]  new_sr,
  output logic [AW-1:0]    ret_addr,
  output logic [AW-1:0]    sp_al,
  output logic [AW-1:0]    isp_al,
  output logic             throwaway
);

  localparam logic [VEC_W-1:0] TRAP_LO = VEC_W'(32);
  localparam logic [VEC_W-1:0] TRAP_HI = VEC_W'(47);
  localparam logic [VEC_W-1:0] IRQ_LO  = VEC_W'(24);
  localparam logic [VEC_W-1:0] IRQ_HI  = VEC_W'(31);

  logic is_trap;
  logic is_irq_vec;

  function automatic logic [AW-1:0] align_sp(input logic [AW-1:0] p);
    return UNALIGNED_OK ? p : {p[AW-1:1], 1'b0};
  endfunction

  always_comb begin
    is_trap    = (exc_num >= TRAP_LO) && (exc_num <= TRAP_HI);
    is_irq_vec = (exc_num >= IRQ_LO) && (exc_num <= IRQ_HI);
    ret_addr   = pc_in + (is_trap ? AW'(2) : AW'(0));
    throwaway  = is_hw && sr_in[SR_M_BIT] && is_irq_vec;

    new_sr                    = sr_in;
    new_sr[SR_S_BIT]          = 1'b1;
    new_sr[SR_T_HI:SR_T_LO]   = 2'b00;
    if (is_hw) new_sr[SR_I_LO+IPL_W-1:SR_I_LO] = ipl;

    sp_al  = align_sp(sp_in);
    isp_al = align_sp(isp_in);
  end

endmodule

// File: rtl/esf_access_gen.sv
module esf_access_gen
  import esf_pkg::*;
#(
  parameter int AW    = 32,
  parameter int VEC_W = 8
) (
  input  esf_state_e        st,
  input  esf_kind_e         kind,
  input  logic [3:0]        fmt,
  input  logic [VEC_W-1:0]  vnum,
  input  logic [AW-1:0]     sp,
  input  logic [AW-1:0]     vbr,
  input  logic [AW-1:0]     pc,
  input  logic [AW-1:0]     fa,
  input  logic [AW-1:0]     ret,
  input  logic [SR_W-1:0]   stk_sr,
  output logic              req,
  output logic              we,
  output logic              lng,
  output logic [AW-1:0]     addr,
  output logic [LONG_W-1:0] wdata
);

  logic [11:0] vec_off;
  logic [15:0] fvw;

  always_comb begin
    vec_off = 12'({vnum, 2'b00});
    fvw     = {fmt, vec_off};
    req     = 1'b0;
    we      = 1'b0;
    lng     = 1'b0;
    addr    = sp;
    wdata   = '0;
    case (st)
      ST_PUSH: begin
        req  = 1'b1;
        we   = 1'b1;
        lng  = kind_is_long(kind);
        addr = sp - (lng ? AW'(4) : AW'(2));
        case (kind)
          K_EXT_PC:   wdata = LONG_W'(pc);
          K_EXT_ADDR: wdata = LONG_W'(fa);
          K_FVW:      wdata = {16'h0000, fvw};
          K_RET:      wdata = LONG_W'(ret);
          default:    wdata = {16'h0000, stk_sr};
        endcase
      end
      ST_VEC: begin
        req  = 1'b1;
        lng  = 1'b1;
        addr = vbr + AW'({vnum, 2'b00});
      end
      ST_POP_SR, ST_POP_FVW: begin
        req = 1'b1;
      end
      ST_POP_PC: begin
        req = 1'b1;
        lng = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/exc_frame_engine.sv
module exc_frame_engine
  import esf_pkg::*;
#(
  parameter int AW           = 32,
  parameter int VEC_W        = 8,
  parameter bit UNALIGNED_OK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              entry_go,
  input  logic              return_go,
  input  logic [VEC_W-1:0]  exc_num,
  input  logic              is_hw,
  input  logic [15:0]       sr_in,
  input  logic [AW-1:0]     pc_in,
  input  logic [AW-1:0]     sp_in,
  input  logic [AW-1:0]     isp_in,
  input  logic [2:0]        ipl,
  input  logic [AW-1:0]     fault_addr,
  input  logic [3:0]        frame_fmt,
  input  logic [AW-1:0]     vbr,
  output logic              busy,
  output logic              done,
  output logic [15:0]       sr_out,
  output logic [AW-1:0]     pc_out,
  output logic [AW-1:0]     sp_out,
  output logic [AW-1:0]     msp_out,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_long,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack
);

  esf_state_e        st;
  esf_kind_e         kind;
  logic              frame2, thr_r, mode_ret;
  logic [3:0]        fmt_r;
  logic [VEC_W-1:0]  vnum_r;
  logic [AW-1:0]     sp_r, isp_r, ret_r, pc_r, fa_r, vbr_r, msp_r, pop_pc;
  logic [SR_W-1:0]   stk_sr, wsr_r, pop_sr;

  logic [SR_W-1:0]   c_sr;
  logic [AW-1:0]     c_ret, c_sp, c_isp;
  logic              c_thr;

  // Named internal events
  logic              fire, push_last, frame_switch, pop_fmt1;
  logic [3:0]        rd_fmt;
  logic [AW-1:0]     unwind_sp;

  esf_entry_calc #(.AW(AW), .VEC_W(VEC_W), .UNALIGNED_OK(UNALIGNED_OK)) u_calc (
    .exc_num   (exc_num),
    .is_hw     (is_hw),
    .sr_in     (sr_in),
    .pc_in     (pc_in),
    .sp_in     (sp_in),
    .isp_in    (isp_in),
    .ipl       (ipl),
    .new_sr    (c_sr),
    .ret_addr  (c_ret),
    .sp_al     (c_sp),
    .isp_al    (c_isp),
    .throwaway (c_thr)
  );

  esf_access_gen #(.AW(AW), .VEC_W(VEC_W)) u_acc (
    .st     (st),
    .kind   (kind),
    .fmt    (fmt_r),
    .vnum   (vnum_r),
    .sp     (sp_r),
    .vbr    (vbr_r),
    .pc     (pc_r),
    .fa     (fa_r),
    .ret    (ret_r),
    .stk_sr (stk_sr),
    .req    (mem_req),
    .we     (mem_we),
    .lng    (mem_long),
    .addr   (mem_addr),
    .wdata  (mem_wdata)
  );

  assign busy         = (st != ST_IDLE);
  assign fire         = mem_req && mem_ack;
  assign push_last    = fire && (st == ST_PUSH) && (kind == K_SR);
  assign frame_switch = push_last && thr_r;
  assign rd_fmt       = mem_rdata[15:12];
  assign pop_fmt1     = fire && (st == ST_POP_FVW) && (rd_fmt == 4'd1);
  assign unwind_sp    = sp_r + AW'(2) + AW'(unwind_skip(rd_fmt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      kind     <= K_FVW;
      frame2   <= 1'b0;
      thr_r    <= 1'b0;
      mode_ret <= 1'b0;
      fmt_r    <= '0;
      vnum_r   <= '0;
      sp_r     <= '0;
      isp_r    <= '0;
      ret_r    <= '0;
      pc_r     <= '0;
      fa_r     <= '0;
      vbr_r    <= '0;
      msp_r    <= '0;
      pop_pc   <= '0;
      stk_sr   <= '0;
      wsr_r    <= '0;
      pop_sr   <= '0;
      done     <= 1'b0;
      sr_out   <= '0;
      pc_out   <= '0;
      sp_out   <= '0;
      msp_out  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (entry_go) begin
            st       <= ST_PUSH;
            mode_ret <= 1'b0;
            fmt_r    <= c_thr ? 4'd0 : frame_fmt;
            kind     <= first_kind(c_thr ? 4'd0 : frame_fmt);
            thr_r    <= c_thr;
            frame2   <= 1'b0;
            stk_sr   <= sr_in;
            wsr_r    <= c_sr;
            sp_r     <= c_sp;
            msp_r    <= c_sp;
            isp_r    <= c_isp;
            ret_r    <= c_ret;
            pc_r     <= pc_in;
            fa_r     <= fault_addr;
            vbr_r    <= vbr;
            vnum_r   <= exc_num;
          end else if (return_go) begin
            st       <= ST_POP_SR;
            mode_ret <= 1'b1;
            sp_r     <= sp_in;
          end
        end
        ST_PUSH: if (fire) begin
          sp_r <= mem_addr;
          if (kind == K_SR) begin
            if (!frame2) msp_r <= mem_addr;
            if (thr_r) begin
              // second frame on the interrupt stack, carrying the new status
              thr_r            <= 1'b0;
              frame2           <= 1'b1;
              fmt_r            <= 4'd1;
              kind             <= first_kind(4'd1);
              stk_sr           <= wsr_r;
              wsr_r[SR_M_BIT]  <= 1'b0;
              sp_r             <= isp_r;
            end else begin
              st <= ST_VEC;
            end
          end else begin
            kind <= next_kind(kind);
          end
        end
        ST_VEC: if (fire) begin
          pc_out  <= mem_rdata[AW-1:0];
          sp_out  <= sp_r;
          sr_out  <= wsr_r;
          msp_out <= msp_r;
          done    <= 1'b1;
          st      <= ST_IDLE;
        end
        ST_POP_SR: if (fire) begin
          pop_sr <= mem_rdata[15:0];
          sp_r   <= sp_r + AW'(2);
          st     <= ST_POP_PC;
        end
        ST_POP_PC: if (fire) begin
          pop_pc <= mem_rdata[AW-1:0];
          sp_r   <= sp_r + AW'(4);
          st     <= ST_POP_FVW;
        end
        ST_POP_FVW: if (fire) begin
          if (pop_fmt1) begin
            sp_r <= sp_r + AW'(2);
            st   <= ST_POP_SR;
          end else begin
            sr_out  <= pop_sr;
            pc_out  <= pop_pc;
            sp_out  <= unwind_sp;
            msp_out <= unwind_sp;
            done    <= 1'b1;
            st      <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_long)));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_entry_sr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode_ret) |-> (sr_out[SR_S_BIT] && (sr_out[SR_T_HI:SR_T_LO] == 2'b00)));

  p_ret_readonly_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_ret) |-> !mem_we);

  p_switch_clears_m_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_switch |=> (!wsr_r[SR_M_BIT] && frame2 && (st == ST_PUSH)));

  p_vec_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_VEC && mem_req) |-> (mem_long && !mem_we));

  generate
    if (!UNALIGNED_OK) begin : g_align_chk
      p_even_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_addr[0]);
    end
  endgenerate

endmodule

// File: tb/tb_exc_frame_engine.sv
`timescale 1ns/1ps
module tb_exc_frame_engine;

  localparam int AW = 32;
  localparam int VW = 8;
  localparam logic [31:0] VBR = 32'h0000_4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          entry_go = 0, return_go = 0, is_hw = 0;
  logic [VW-1:0] exc_num = '0;
  logic [15:0]   sr_in = '0;
  logic [31:0]   pc_in = '0, sp_in = '0, isp_in = '0, fault_addr = '0, vbr = VBR;
  logic [2:0]    ipl = '0;
  logic [3:0]    frame_fmt = '0;
  logic          busy, done, mem_req, mem_we, mem_long;
  logic [15:0]   sr_out;
  logic [31:0]   pc_out, sp_out, msp_out, mem_addr, mem_wdata;
  logic [31:0]   mem_rdata = '0;
  logic          mem_ack = 1'b0;

  int checks = 0;
  int fails  = 0;

  exc_frame_engine #(.AW(AW), .VEC_W(VW), .UNALIGNED_OK(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .entry_go(entry_go), .return_go(return_go),
    .exc_num(exc_num), .is_hw(is_hw), .sr_in(sr_in), .pc_in(pc_in),
    .sp_in(sp_in), .isp_in(isp_in), .ipl(ipl), .fault_addr(fault_addr),
    .frame_fmt(frame_fmt), .vbr(vbr), .busy(busy), .done(done),
    .sr_out(sr_out), .pc_out(pc_out), .sp_out(sp_out), .msp_out(msp_out),
    .mem_req(mem_req), .mem_we(mem_we), .mem_long(mem_long),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack)
  );

  // ---------------- big-endian byte memory ----------------
  logic [7:0] mem [logic [31:0]];

  function automatic logic [7:0] rb(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction
  function automatic logic [15:0] rd16(input logic [31:0] a);
    return {rb(a), rb(a + 1)};
  endfunction
  function automatic logic [31:0] rd32(input logic [31:0] a);
    return {rb(a), rb(a + 1), rb(a + 2), rb(a + 3)};
  endfunction
  task automatic wr16(input logic [31:0] a, input logic [15:0] d);
    mem[a] = d[15:8]; mem[a + 1] = d[7:0];
  endtask
  task automatic wr32(input logic [31:0] a, input logic [31:0] d);
    wr16(a, d[31:16]); wr16(a + 2, d[15:0]);
  endtask

  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        if (mem_long) wr32(mem_addr, mem_wdata);
        else wr16(mem_addr, mem_wdata[15:0]);
      end else begin
        mem_rdata <= mem_long ? rd32(mem_addr) : {16'h0000, rd16(mem_addr)};
      end
    end else mem_ack <= 1'b0;
  end

  function automatic logic [31:0] vecpat(input int n);
    return 32'h00A0_0000 + 32'(n) * 32'h104;
  endfunction

  // ---------------- checking helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 1000) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      fails++;
      $display("FAIL R11 no done pulse act=0 exp=1");
    end
  endtask

  task automatic start_entry(input int e, input logic hw, input logic [15:0] sr,
                             input logic [31:0] pc, input logic [31:0] sp,
                             input logic [31:0] isp, input logic [2:0] lv,
                             input logic [31:0] fa, input logic [3:0] f);
    @(negedge clk);
    exc_num = VW'(e); is_hw = hw; sr_in = sr; pc_in = pc; sp_in = sp;
    isp_in = isp; ipl = lv; fault_addr = fa; frame_fmt = f;
    entry_go = 1'b1;
    @(negedge clk);
    entry_go = 1'b0;
  endtask

  task automatic start_return(input logic [31:0] sp);
    @(negedge clk);
    sp_in = sp;
    return_go = 1'b1;
    @(negedge clk);
    return_go = 1'b0;
  endtask

  // Independent model of an entry, checked after done
  task automatic check_entry(input int e, input logic hw, input logic [15:0] sr,
                             input logic [31:0] pc, input logic [31:0] sp,
                             input logic [31:0] isp, input logic [2:0] lv,
                             input logic [31:0] fa, input logic [3:0] f);
    logic [31:0] top, itop, ret, b, b1;
    logic [15:0] nsr;
    logic        thr;
    int          extra;
    top  = sp & ~32'h1;
    itop = isp & ~32'h1;
    ret  = (e >= 32 && e <= 47) ? pc + 2 : pc;
    nsr  = (sr | 16'h2000) & 16'h3FFF;
    if (hw) nsr = (nsr & ~16'h0700) | {5'b0, lv, 8'h00};
    thr  = hw && sr[12] && e >= 24 && e <= 31;
    chk("R8 vector pc", pc_out, vecpat(e));
    if (!thr) begin
      extra = (f == 4) ? 8 : ((f == 2 || f == 3) ? 4 : 0);
      b = top - 32'(8 + extra);
      chk("R1 sp_out base", sp_out, b);
      chk("R7 msp equals sp", msp_out, b);
      chk("R5 stacked sr", {16'h0, rd16(b)}, {16'h0, sr});
      chk("R4 return addr", rd32(b + 2), ret);
      chk("R2 fmt/vec word", {16'h0, rd16(b + 6)}, {16'h0, f, 12'(e * 4)});
      if (extra > 0) chk("R3 fault addr", rd32(b + 8), fa);
      if (extra == 8) chk("R3 fmt4 pc", rd32(b + 12), pc);
      chk("R5 new sr", {16'h0, sr_out}, {16'h0, nsr});
      chk("R6 even base", {31'h0, sp_out[0]}, 32'h0);
    end else begin
      b  = top - 32'd8;
      b1 = itop - 32'd8;
      chk("R7 first frame base", msp_out, b);
      chk("R7 first sr", {16'h0, rd16(b)}, {16'h0, sr});
      chk("R7 first ret", rd32(b + 2), ret);
      chk("R7 first fvw", {16'h0, rd16(b + 6)}, {16'h0, 4'h0, 12'(e * 4)});
      chk("R7 second base", sp_out, b1);
      chk("R7 second sr", {16'h0, rd16(b1)}, {16'h0, nsr});
      chk("R7 second ret", rd32(b1 + 2), ret);
      chk("R7 second fvw", {16'h0, rd16(b1 + 6)}, {16'h0, 4'h1, 12'(e * 4)});
      chk("R7 final sr M clear", {16'h0, sr_out}, {16'h0, nsr & ~16'h1000});
    end
  endtask

  int exl[10] = '{2, 3, 5, 24, 25, 31, 32, 40, 47, 64};
  int fml[4]  = '{0, 2, 3, 4};

  initial begin
    logic [31:0] s, keep_sp;
    logic [15:0] sr;
    logic [31:0] sp, isp, pc, fa, ret;
    logic        thr;
    for (int n = 0; n < 256; n++) wr32(VBR + 32'(n * 4), vecpat(n));
    repeat (3) @(negedge clk);
    chk("R11 reset busy", {31'h0, busy}, 32'h0);
    chk("R11 reset done", {31'h0, done}, 32'h0);
    chk("R11 reset req", {31'h0, mem_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle req", {31'h0, mem_req}, 32'h0);

    // Sweep of entries plus round trip returns
    foreach (exl[i]) foreach (fml[j])
      for (int hw = 0; hw < 2; hw++)
        for (int ms = 0; ms < 2; ms++)
          for (int od = 0; od < 2; od++) begin
            sr  = (ms ? 16'h9000 : 16'h4000) | 16'h0315;
            sp  = 32'h8000 + 32'(od);
            isp = 32'hC000 + 32'(od);
            pc  = 32'h0001_0000 + 32'(exl[i] * 16);
            fa  = 32'hFA00_0000 + 32'(exl[i]);
            start_entry(exl[i], hw[0], sr, pc, sp, isp, 3'((exl[i] % 7) + 1), fa, 4'(fml[j]));
            wait_done();
            check_entry(exl[i], hw[0], sr, pc, sp, isp, 3'((exl[i] % 7) + 1), fa, 4'(fml[j]));
            thr = hw[0] && ms[0] && exl[i] >= 24 && exl[i] <= 31;
            if (!thr) begin
              ret = (exl[i] >= 32 && exl[i] <= 47) ? pc + 2 : pc;
              start_return(sp_out);
              wait_done();
              chk("R9 round trip sr", {16'h0, sr_out}, {16'h0, sr});
              chk("R9 round trip pc", pc_out, ret);
              chk("R9 round trip sp", sp_out, sp & ~32'h1);
            end
          end

    // Return of a format 7 frame
    s = 32'h6000;
    wr16(s, 16'h2704); wr32(s + 2, 32'h1234_5678); wr16(s + 6, 16'h7008);
    start_return(s); wait_done();
    chk("R9 fmt7 sp", sp_out, s + 60);
    chk("R9 fmt7 msp", msp_out, s + 60);
    chk("R9 fmt7 sr", {16'h0, sr_out}, 32'h2704);
    chk("R9 fmt7 pc", pc_out, 32'h1234_5678);

    // Unknown format 5 skips nothing
    s = 32'h6100;
    wr16(s, 16'h0011); wr32(s + 2, 32'h0000_0AAA); wr16(s + 6, 16'h5010);
    start_return(s); wait_done();
    chk("R9 fmt5 sp", sp_out, s + 8);
    chk("R9 fmt5 pc", pc_out, 32'h0000_0AAA);

    // Format 1 chain: throwaway frame then a format 2 frame above it
    s = 32'h6200;
    wr16(s, 16'h3700); wr32(s + 2, 32'hDEAD_0001); wr16(s + 6, 16'h1064);
    wr16(s + 8, 16'h0700); wr32(s + 10, 32'h0002_2220); wr16(s + 14, 16'h2018);
    start_return(s); wait_done();
    chk("R10 chained sr", {16'h0, sr_out}, 32'h0700);
    chk("R10 chained pc", pc_out, 32'h0002_2220);
    chk("R10 chained sp", sp_out, s + 20);

    // Start requests while busy are ignored; outputs hold while busy
    keep_sp = sp_out;
    start_entry(5, 1'b0, 16'h0000, 32'h0000_0100, 32'h7000, 32'hC000, 3'd0, 32'h0, 4'd0);
    chk("R11 outputs hold while busy", sp_out, keep_sp);
    sp_in = 32'h5000;
    entry_go = 1'b1; return_go = 1'b1;
    @(negedge clk);
    entry_go = 1'b0; return_go = 1'b0;
    wait_done();
    chk("R11 go ignored while busy sp", sp_out, 32'h7000 - 8);
    chk("R11 go ignored while busy pc", pc_out, vecpat(5));
    @(negedge clk);
    chk("R11 single done pulse", {31'h0, done}, 32'h0);
    repeat (3) @(negedge clk);
    chk("R11 no restarted sequence", {31'h0, busy}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule